// File: doc/BRIEF.md
# Subcarrier Edge-Count Bit Receiver

This block recovers a tag's reply to a reader when the reply carries no framing of its own: no preamble, no start or stop marker and no length field. The reader already knows how many bits it expects. Its own transmitter marks the end of the outgoing frame with a one-cycle sync pulse. The receiver measures every bit window from that pulse. The first window opens after a fixed guard time. Further windows follow back to back, and each lasts a fixed number of timebase ticks. A tick enable from a clock divider provides the timebase.

The digitised subcarrier input first passes through a two-flop synchroniser. Every level change inside a window, rising or falling, adds one to an edge counter. When the window closes, a count inside an open band becomes a 1-bit, and any other count becomes a 0-bit. The subcarrier normally gives about 42 edges per window, while a silent carrier gives none. Bits enter the word least significant bit first. After the last expected bit, the word is held and a one-cycle valid pulse is raised. A reply of all zeros looks the same as no tag at all, so it is reported like any other word.

Top module: `sc_edge_rx`

## Requirements
- R1: After `frame_sync` is sampled high, the first bit window opens WAIT_TICKS (default 490) ticks later. Each window lasts BIT_TICKS (default 150) ticks, and windows follow each other with no gap. Only cycles with `tick_en` high advance time. With `tick_en` held high and `bit_count` = n (1..16), `rx_valid` is high in the cycle after clock edge 490 + 150*n, counting the sync edge as edge 0.
- R2: A window that holds E edges decodes as 1 when 20 < E < 60 and as 0 otherwise. For example, 20 gives 0, 21 gives 1, 59 gives 1 and 60 gives 0.
- R3: The bit of window k (k = 0 for the first window) is placed at `rx_word[k]`. Bits at positions `bit_count` and above are 0.
- R4: `rx_valid` is a pulse exactly one cycle wide that coincides with the final word. After it, `rx_word` stays unchanged until the next `frame_sync`.
- R5: `frame_sync` clears `rx_word` to 0 and restarts timing from the beginning, even while a reception is in progress. A partly received frame never produces a valid pulse.
- R6: A `bit_count` of 0 produces a `rx_valid` pulse with `rx_word` = 0 in the cycle after the sync edge. Values above 16 are treated as 16.
- R7: A reply whose windows all hold fewer than 21 edges completes normally, with `rx_valid` high and `rx_word` = 0. No error is signalled.
- R8: Edges count in both directions after two-flop synchronisation, and only while a bit window is open. Toggles during the guard time after sync have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_sync | input | 1 | One-cycle pulse at the reader frame end; starts a reception |
| bit_count | input | 5 | Number of bits expected, sampled with `frame_sync` |
| tick_en | input | 1 | Timebase tick enable |
| rx_in | input | 1 | Thresholded subcarrier input, asynchronous |
| rx_word | output | 16 | Received word, LSB first |
| rx_valid | output | 1 | One-cycle pulse when the word is complete |

## Verification
The bench drives edge counts on both sides of each threshold: 20, 21, 59 and 60. A design that used inclusive comparisons would swap those bits. Exact pulse timing with an ungated tick exposes an off-by-one in the guard time or the window length, because such a design would pulse one or more cycles early or late. Bursts of toggles during the guard time, a restart in the middle of a frame, a bit count of 0 and a bit count above 16 each target a specific error. A design that counted outside the windows would corrupt bit 0. A design that ignored the restart would pulse for the aborted frame. A design with a wrong count limit would hang or overflow the mask. A run with the tick gated to every other cycle shows whether the timebase follows `tick_en` or the raw clock.

// File: rtl/sc_rx_pkg.sv
package sc_rx_pkg;

  localparam int EDGE_W = 8;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WAIT = 2'd1,
    PH_BIT  = 2'd2
  } phase_t;

  // Edge count strictly inside the open band (lo, hi) decodes as a 1-bit.
  function automatic logic decide_bit(input logic [EDGE_W-1:0] n,
                                      input int lo, input int hi);
    return (int'(n) > lo) && (int'(n) < hi);
  endfunction

  // Saturating increment of an edge count.
  function automatic logic [EDGE_W-1:0] sat_inc(input logic [EDGE_W-1:0] n,
                                                input logic inc);
    if (inc && (n != {EDGE_W{1'b1}})) return n + 1'b1;
    return n;
  endfunction

  // Requested bit count limited to the word width.
  function automatic int clip_count(input int req, input int width);
    return (req > width) ? width : req;
  endfunction

endpackage

// File: rtl/sc_rx_sync.sv
module sc_rx_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_prev,
  input  logic din,
  output logic edge_evt
);
  logic s1, s2, prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= 1'b0;
      s2   <= 1'b0;
      prev <= 1'b0;
    end else begin
      s1   <= din;
      s2   <= s1;
      prev <= clr_prev ? 1'b0 : s2;
    end
  end

  assign edge_evt = (s2 != prev);
endmodule

// File: rtl/sc_rx_timer.sv
module sc_rx_timer
  import sc_rx_pkg::*;
#(
  parameter int WAIT_TICKS = 490,
  parameter int BIT_TICKS  = 150
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic arm,
  input  logic tick_en,
  input  logic last_bit,
  output logic win_open,
  output logic win_close,
  output logic in_bit,
  output logic busy
);
  localparam int MAXT = (WAIT_TICKS > BIT_TICKS) ? WAIT_TICKS : BIT_TICKS;
  localparam int TW   = $clog2(MAXT + 1);
  localparam logic [TW-1:0] WAIT_END = TW'(WAIT_TICKS - 1);
  localparam logic [TW-1:0] BIT_END  = TW'(BIT_TICKS - 1);

  phase_t        ph;
  logic [TW-1:0] tcnt;

  assign win_open  = !start && tick_en && (ph == PH_WAIT) && (tcnt == WAIT_END);
  assign win_close = !start && tick_en && (ph == PH_BIT)  && (tcnt == BIT_END);
  assign in_bit    = (ph == PH_BIT);
  assign busy      = (ph != PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph   <= PH_IDLE;
      tcnt <= '0;
    end else if (start) begin
      ph   <= arm ? PH_WAIT : PH_IDLE;
      tcnt <= '0;
    end else if (tick_en) begin
      unique case (ph)
        PH_WAIT: begin
          if (win_open) begin
            ph   <= PH_BIT;
            tcnt <= '0;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        PH_BIT: begin
          if (win_close) begin
            tcnt <= '0;
            if (last_bit) ph <= PH_IDLE;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        default: tcnt <= '0;
      endcase
    end
  end
endmodule

// File: rtl/sc_rx_assembler.sv
module sc_rx_assembler
  import sc_rx_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 5,
  parameter int LO_THR = 20,
  parameter int HI_THR = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  req_bits,
  input  logic              win_open,
  input  logic              win_close,
  input  logic              in_bit,
  input  logic              edge_evt,
  output logic              last_bit,
  output logic [EDGE_W-1:0] edge_cnt,
  output logic [WORD_W-1:0] mask,
  output logic [WORD_W-1:0] word,
  output logic              valid
);
  logic [CNT_W-1:0]  target, done;
  logic [EDGE_W-1:0] closing_cnt;
  logic              bit_val;
  logic [CNT_W-1:0]  req_clip;

  assign req_clip    = CNT_W'(clip_count(int'(req_bits), WORD_W));
  assign last_bit    = (done == target - 1'b1);
  assign closing_cnt = sat_inc(edge_cnt, edge_evt);
  assign bit_val     = decide_bit(closing_cnt, LO_THR, HI_THR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      target   <= '0;
      done     <= '0;
      edge_cnt <= '0;
      mask     <= WORD_W'(1);
      word     <= '0;
      valid    <= 1'b0;
    end else if (start) begin
      target   <= req_clip;
      done     <= '0;
      edge_cnt <= '0;
      mask     <= WORD_W'(1);
      word     <= '0;
      valid    <= (req_clip == '0);
    end else begin
      valid <= 1'b0;
      if (win_close) begin
        if (bit_val) word <= word | mask;
        mask     <= mask << 1;
        done     <= done + 1'b1;
        edge_cnt <= '0;
        valid    <= last_bit;
      end else if (win_open) begin
        edge_cnt <= '0;
      end else if (in_bit) begin
        edge_cnt <= closing_cnt;
      end
    end
  end
endmodule

// File: rtl/sc_edge_rx.sv
module sc_edge_rx #(
  parameter int WAIT_TICKS = 490,
  parameter int BIT_TICKS  = 150,
  parameter int LO_THR     = 20,
  parameter int HI_THR     = 60,
  parameter int WORD_W     = 16,
  localparam int CNT_W     = $clog2(WORD_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_sync,
  input  logic [CNT_W-1:0]  bit_count,
  input  logic              tick_en,
  input  logic              rx_in,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_valid
);
  logic                          edge_evt, win_open, win_close, in_bit, busy;
  logic                          last_bit;
  logic                          arm;
  logic [sc_rx_pkg::EDGE_W-1:0]  edge_cnt;
  logic [WORD_W-1:0]             mask;

  assign arm = (bit_count != '0);

  sc_rx_sync u_sync (
    .clk(clk), .rst_n(rst_n), .clr_prev(frame_sync),
    .din(rx_in), .edge_evt(edge_evt)
  );

  sc_rx_timer #(.WAIT_TICKS(WAIT_TICKS), .BIT_TICKS(BIT_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(frame_sync), .arm(arm),
    .tick_en(tick_en), .last_bit(last_bit),
    .win_open(win_open), .win_close(win_close), .in_bit(in_bit), .busy(busy)
  );

  sc_rx_assembler #(.WORD_W(WORD_W), .CNT_W(CNT_W),
                    .LO_THR(LO_THR), .HI_THR(HI_THR)) u_asm (
    .clk(clk), .rst_n(rst_n), .start(frame_sync), .req_bits(bit_count),
    .win_open(win_open), .win_close(win_close), .in_bit(in_bit),
    .edge_evt(edge_evt), .last_bit(last_bit), .edge_cnt(edge_cnt),
    .mask(mask), .word(rx_word), .valid(rx_valid)
  );
endmodule

// File: rtl/sc_edge_rx_chk.sv
module sc_edge_rx_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_sync,
  input logic              win_open,
  input logic              win_close,
  input logic              busy,
  input logic [7:0]        edge_cnt,
  input logic [WORD_W-1:0] mask,
  input logic [WORD_W-1:0] rx_word,
  input logic              rx_valid
);
  // R4: valid lasts exactly one cycle
  p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R4: word frozen while idle and no restart
  p_hold_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !frame_sync) |=> $stable(rx_word));

  // R5: sync clears the word
  p_sync_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |=> (rx_word == '0));

  // R3: bit position mask is at most one-hot
  p_mask_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mask));

  // R8: edge counter starts every window from zero
  p_ecnt_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (win_open || win_close) && !frame_sync |=> (edge_cnt == '0));

  // R1: valid only follows a window close or a zero-length start
  p_valid_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(win_close || frame_sync));
endmodule

bind sc_edge_rx sc_edge_rx_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync),
  .win_open(win_open), .win_close(win_close), .busy(busy),
  .edge_cnt(edge_cnt), .mask(mask), .rx_word(rx_word), .rx_valid(rx_valid)
);

// File: tb/sc_edge_rx_test.sv
module sc_edge_rx_test;
  localparam int CLK_PERIOD = 10;
  localparam int WAIT_T = 490;
  localparam int BIT_T  = 150;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_sync = 1'b0;
  logic [4:0]  bit_count = '0;
  logic        tick_en = 1'b1;
  logic        tick_gate = 1'b0;
  logic        rx_in = 1'b0;
  logic [15:0] rx_word;
  logic        rx_valid;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) tick_en <= tick_gate ? ~tick_en : 1'b1;

  sc_edge_rx uut (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .bit_count(bit_count),
    .tick_en(tick_en), .rx_in(rx_in), .rx_word(rx_word), .rx_valid(rx_valid)
  );

  function automatic bit exp_bit(input int e);
    return (e >= 21) && (e <= 59);
  endfunction

  function automatic logic [15:0] exp_word(input int n, input int c[16]);
    logic [15:0] w = '0;
    int lim = (n > 16) ? 16 : n;
    for (int k = 0; k < lim; k++) w[k] = exp_bit(c[k]);
    return w;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_sync(input int n);
    @(negedge clk);
    bit_count  = 5'(n);
    frame_sync = 1'b1;
    @(posedge clk);
    @(negedge clk);
    frame_sync = 1'b0;
  endtask

  // Spend len posedges; toggle rx_in cnt times starting at offset 6, every 2 cycles.
  task automatic span(input int len, input int cnt);
    for (int c = 0; c < len; c++) begin
      @(posedge clk);
      if (c >= 6 && c < 6 + 2*cnt && ((c - 6) % 2 == 0)) begin
        @(negedge clk);
        rx_in = ~rx_in;
      end
    end
  endtask

  // The sync task ends at the negedge after edge 0; span consumes edges 1..
  task automatic run_frame(input int n, input int c[16], input int scale,
                           input int noise, input string req);
    int lim = (n > 16) ? 16 : n;
    logic [15:0] w;
    logic [15:0] ew;
    int found;
    pulse_sync(n);
    span(WAIT_T*scale - 1, noise);
    @(posedge clk);
    for (int k = 0; k < lim; k++) span(BIT_T*scale, c[k]);
    ew = exp_word(n, c);
    found = -1;
    for (int t = 0; t < 8 && found < 0; t++) begin
      @(negedge clk);
      if (rx_valid) found = t;
    end
    if (scale == 1) check(found == 0, "R1 valid timing", found, 0);
    else            check(found >= 0, "R1 gated valid", found, 0);
    w = rx_word;
    check(w == ew, req, int'(w), int'(ew));
    @(negedge clk);
    check(!rx_valid, "R4 single pulse", int'(rx_valid), 0);
    repeat (40) @(negedge clk);
    check(rx_word == ew, "R4 hold", int'(rx_word), int'(ew));
  endtask

  initial begin
    int c[16];
    int seed;
    seed = $urandom(32'h5eed_0042);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rx_word == 0, "R4 reset word", int'(rx_word), 0);
    check(!rx_valid, "R4 reset valid", int'(rx_valid), 0);

    // R2 thresholds and R3 ordering
    c = '{20, 21, 59, 60, 42, 0, 5, 65, 42, 19, 22, 61, 58, 1, 42, 0};
    run_frame(16, c, 1, 0, "R2 thresholds");
    c = '{42, 0, 0, 42, 42, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    run_frame(5, c, 1, 0, "R3 lsb first");
    // R3 bits above count stay zero
    c = '{42, 42, 42, 42, 42, 42, 42, 42, 42, 42, 42, 42, 42, 42, 42, 42};
    run_frame(3, c, 1, 0, "R3 upper zero");
    // R7 all-zero reply
    c = '{0, 3, 20, 0, 60, 0, 0, 64, 0, 0, 0, 0, 0, 0, 0, 0};
    run_frame(8, c, 1, 0, "R7 all zero");
    // R8 guard-time noise ignored
    c = '{21, 0, 42, 20, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    run_frame(4, c, 1, 99, "R8 noise ignored");
    // R6 count above 16 clipped
    c = '{42, 0, 42, 0, 42, 0, 42, 0, 42, 0, 42, 0, 42, 0, 42, 59};
    run_frame(25, c, 1, 0, "R6 clip");

    // R6 zero-length request
    pulse_sync(0);
    check(rx_valid == 1'b1, "R6 zero count valid", int'(rx_valid), 1);
    check(rx_word == 0, "R6 zero count word", int'(rx_word), 0);
    @(negedge clk);
    check(!rx_valid, "R6 zero count pulse", int'(rx_valid), 0);

    // R5 mid-frame restart: no pulse for the aborted frame
    begin
      int seen = 0;
      pulse_sync(6);
      for (int i = 0; i < WAIT_T + 2*BIT_T; i++) begin
        @(negedge clk);
        if (rx_valid) seen++;
      end
      check(seen == 0, "R5 no early valid", seen, 0);
    end
    c = '{0, 42, 42, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    run_frame(3, c, 1, 0, "R5 restart word");

    // R1 gated timebase
    tick_gate = 1'b1;
    c = '{42, 0, 30, 42, 0, 50, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    run_frame(6, c, 2, 0, "R1 gated word");
    tick_gate = 1'b0;
    repeat (3) @(negedge clk);

    // Random frames
    for (int f = 0; f < 6; f++) begin
      int n = 1 + int'($urandom_range(15, 0));
      for (int k = 0; k < 16; k++) c[k] = int'($urandom_range(65, 0));
      run_frame(n, c, 1, int'($urandom_range(40, 0)), "R2 random");
    end

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
    end
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
    end
    $finish;
  end
endmodule